// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Prescaler

This block is a supervision timer. A 16-bit up-counter advances once per prescaler period. The prescaler divides the system clock by 2 or by 128, and a single select input chooses the ratio. Software must strobe the service input from time to time. Each strobe places an 8-bit software value in the upper byte of the counter, zeroes the lower byte and restarts the prescaler. Choosing that upper byte sets how many counts remain before the counter wraps.

If the counter passes from 0xFFFF to 0x0000 before the next service, the block raises a one-cycle reset request for the system reset logic. On the same edge it reloads itself as a service would. A disable input freezes the timer. The count is visible on an output but cannot be written except through the service path.

Top module: `wdt_svc_timer`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `wdt_count` is 0x0000, `wdt_expired` is 0 and the prescaler phase is zero.
- R2: With `div_sel` = 0 the counter advances by exactly one every 2 clock cycles. With `div_sel` = 1 it advances by exactly one every 128 clock cycles. It never changes by any other step except through R3 or R6.
- R3: A clock edge with `kick` high loads `wdt_count` with `{reload_hi, 8'h00}`: bits 15:8 take `reload_hi` and bits 7:0 become zero.
- R4: A kick restarts the prescaler. The first increment after a kick comes a full divide period (2 or 128 edges) after the kick edge.
- R5: When an increment would take the count past 0xFFFF, `wdt_expired` is high for exactly one clock cycle.
- R6: On the edge that raises `wdt_expired`, `wdt_count` becomes `{reload_hi, 8'h00}` using the reload value present at that edge.
- R7: While `freeze` is high and `kick` is low, `wdt_count` and the prescaler phase hold and `wdt_expired` stays low. A kick still acts while frozen.
- R8: If a kick and an overflow fall on the same edge, the kick is applied and `wdt_expired` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 1 | Prescale select: 0 divides by 2, 1 divides by 128 |
| reload_hi | input | 8 | Value placed in the counter's upper byte on kick or expiry |
| kick | input | 1 | Service strobe, sampled on the rising edge |
| freeze | input | 1 | Stops prescaler and counter while high |
| wdt_count | output | 16 | Current counter value (read only) |
| wdt_expired | output | 1 | One-cycle reset request on counter wrap |

## Verification
The embedded assertions watch every cycle for the following:
- the counter's single-step progress;
- the prescaler never ticking on consecutive edges;
- the reload pattern after a kick or an expiry;
- the single-cycle width of the reset request;
- the hold under freeze;
- the kick winning over an overflow.

Only the directed scenarios can show that the step arrives at exactly the 2- or 128-cycle spacing. They also show that a kick restarts the prescaler phase mid-period, and that a real wrap at 0xFFFF produces a pulse at the predicted cycle. These are timing relationships over long windows, and the bench computes them from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WDT_CNT_W    = 16;
    localparam int WDT_RELOAD_W = 8;
    localparam int WDT_DIV_FAST = 2;
    localparam int WDT_DIV_SLOW = 128;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } wdt_rate_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int DIV_FAST = WDT_DIV_FAST,
    parameter int DIV_SLOW = WDT_DIV_SLOW
) (
    input  logic      clk,
    input  logic      rst_n,
    input  wdt_rate_e rate,
    input  logic      restart,
    input  logic      hold,
    output logic      tick
);
    localparam int PRE_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
    localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);
    localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] limit;
    logic             tick_c;

    always_comb begin
        st_d   = st_q;
        limit  = (rate == RATE_SLOW) ? LIM_SLOW : LIM_FAST;
        tick_c = 1'b0;
        if (restart) begin
            st_d.phase = '0;
        end else if (!hold) begin
            if (st_q.phase >= limit) begin
                st_d.phase = '0;
                tick_c     = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = tick_c;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.phase == '0)); // R4
    AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !restart) |=> $stable(st_q.phase)); // R7
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W    = WDT_CNT_W,
    parameter int RELOAD_W = WDT_RELOAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                kick,
    input  logic                hold,
    input  logic [RELOAD_W-1:0] reload_hi,
    output logic [CNT_W-1:0]    count,
    output logic                expired
);
    localparam int LOW_W = CNT_W - RELOAD_W;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] reload_word;

    always_comb begin
        reload_word = {reload_hi, {LOW_W{1'b0}}};
        st_d        = st_q;
        st_d.fire   = 1'b0;
        if (kick) begin
            st_d.cnt = reload_word;
        end else if (step && !hold) begin
            if (st_q.cnt == ALL_ONES) begin
                st_d.cnt  = reload_word;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign expired = st_q.fire;

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !kick |=> (expired || count == $past(count) || count == $past(count) + 1'b1)); // R2
    AST_KICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == {$past(reload_hi), {LOW_W{1'b0}}})); // R3
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired); // R5
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> (count == {$past(reload_hi), {LOW_W{1'b0}}})); // R6
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !kick) |=> ($stable(count) && !expired)); // R7
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !expired); // R8
endmodule

// File: rtl/wdt_svc_timer.sv
module wdt_svc_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W    = WDT_CNT_W,
    parameter int RELOAD_W = WDT_RELOAD_W,
    parameter int DIV_FAST = WDT_DIV_FAST,
    parameter int DIV_SLOW = WDT_DIV_SLOW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                div_sel,
    input  logic [RELOAD_W-1:0] reload_hi,
    input  logic                kick,
    input  logic                freeze,
    output logic [CNT_W-1:0]    wdt_count,
    output logic                wdt_expired
);
    logic      pre_tick;
    wdt_rate_e rate;

    assign rate = wdt_rate_e'(div_sel);

    wdt_prescaler #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (rate),
        .restart (kick),
        .hold    (freeze),
        .tick    (pre_tick)
    );

    wdt_counter #(
        .CNT_W    (CNT_W),
        .RELOAD_W (RELOAD_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (pre_tick),
        .kick      (kick),
        .hold      (freeze),
        .reload_hi (reload_hi),
        .count     (wdt_count),
        .expired   (wdt_expired)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (wdt_count == '0 && !wdt_expired)); // R1
endmodule

// File: tb/wdt_svc_timer_test.sv
module wdt_svc_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_sel = 1'b0;
    logic [7:0]  reload_hi = 8'h00;
    logic        kick = 1'b0;
    logic        freeze = 1'b0;
    logic [15:0] wdt_count;
    logic        wdt_expired;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_svc_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_sel     (div_sel),
        .reload_hi   (reload_hi),
        .kick        (kick),
        .freeze      (freeze),
        .wdt_count   (wdt_count),
        .wdt_expired (wdt_expired)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_kick(input logic [7:0] val);
        reload_hi = val;
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count in reset", wdt_count, 16'h0000);
        chk("R1 expired in reset", {15'd0, wdt_expired}, 16'h0000);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_kick_load();
        div_sel = 1'b0;
        do_kick(8'hA5);
        chk("R3 kick load", wdt_count, 16'hA500);
    endtask

    task automatic t_fast_rate();
        div_sel = 1'b0;
        do_kick(8'h40);
        step(1);
        chk("R2 fast before first step", wdt_count, 16'h4000);
        step(1);
        chk("R2 fast first step", wdt_count, 16'h4001);
        step(8);
        chk("R2 fast after 10 cycles", wdt_count, 16'h4005);
    endtask

    task automatic t_slow_rate();
        div_sel = 1'b1;
        do_kick(8'h3C);
        step(127);
        chk("R2 slow at 127 cycles", wdt_count, 16'h3C00);
        step(1);
        chk("R2 slow at 128 cycles", wdt_count, 16'h3C01);
        step(128);
        chk("R2 slow at 256 cycles", wdt_count, 16'h3C02);
    endtask

    task automatic t_prescaler_restart();
        div_sel = 1'b1;
        do_kick(8'h21);
        step(60);
        do_kick(8'h21);
        step(127);
        chk("R4 no step before full period", wdt_count, 16'h2100);
        step(1);
        chk("R4 step one period after kick", wdt_count, 16'h2101);
    endtask

    task automatic t_expire();
        div_sel = 1'b0;
        do_kick(8'hFF);
        step(511);
        chk("R5 at 0xFFFF no pulse yet", {wdt_expired, wdt_count[14:0]}, {1'b0, 15'h7FFF});
        reload_hi = 8'hC3;
        step(1);
        chk("R5 pulse on wrap", {15'd0, wdt_expired}, 16'h0001);
        chk("R6 reload on wrap", wdt_count, 16'hC300);
        step(1);
        chk("R5 pulse one cycle", {15'd0, wdt_expired}, 16'h0000);
        chk("R6 count holds after wrap", wdt_count, 16'hC300);
    endtask

    task automatic t_collision();
        div_sel = 1'b0;
        do_kick(8'hFF);
        step(511);
        chk("R8 precondition 0xFFFF", wdt_count, 16'hFFFF);
        do_kick(8'h12);
        chk("R8 kick wins count", wdt_count, 16'h1200);
        chk("R8 no pulse on collision", {15'd0, wdt_expired}, 16'h0000);
        step(1);
        chk("R8 no pulse after collision", {15'd0, wdt_expired}, 16'h0000);
    endtask

    task automatic t_freeze();
        bit seen = 1'b0;
        div_sel = 1'b0;
        do_kick(8'hFF);
        step(511);
        freeze = 1'b1;
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (wdt_expired) seen = 1'b1;
        end
        chk("R7 count held while frozen", wdt_count, 16'hFFFF);
        chk("R7 no pulse while frozen", {15'd0, seen}, 16'h0000);
        do_kick(8'h77);
        chk("R7 kick acts while frozen", wdt_count, 16'h7700);
        step(5);
        chk("R7 frozen after kick", wdt_count, 16'h7700);
        freeze = 1'b0;
        step(2);
        chk("R7 runs after release", wdt_count, 16'h7701);
    endtask

    task automatic t_async_reset();
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear count", wdt_count, 16'h0000);
        step(1);
        rst_n = 1'b1;
        step(3);
        chk("R1 prescaler cleared", wdt_count, 16'h0001);
    endtask

    initial begin
        step(2);
        t_reset();
        t_kick_load();
        t_fast_rate();
        t_slow_rate();
        t_prescaler_restart();
        t_expire();
        t_collision();
        t_freeze();
        t_async_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule